// File: doc/BRIEF.md
# Accumulator Fetch-Execute Controller

This block is a small multi-cycle processor core built around one accumulator. It works through separate fetch, decode and execute states and moves data only through its working registers: the program counter, the memory address register, the memory data register, the current instruction register, the accumulator, the index register and a status register. Each instruction is one 16-bit word: a 4-bit opcode in bits 15:12 and a 12-bit address field in bits 11:0. Program and data share a word-addressed internal memory of 4096 words.

A single interrupt request line is latched as a pending request. The core looks at that request only when an instruction has completed. When it accepts the request, it writes its program counter, accumulator and status word to a fixed save area and then continues at a fixed service-routine address. A return instruction reads that state back.

A host port gives direct access to the memory while the core is held in reset or has halted. It is used to load programs and to read back results.

Top module: `accum_core`

## Requirements
- R1: After reset is released the core takes these steps in order. First the memory address register is loaded from the program counter. On the next edge the addressed word is read into the data register and the program counter is incremented by one. Next the instruction register is loaded from the data register, and only then does decode happen. As a result, a halt word at address 0 raises `halted` 4 cycles after reset is released. An instruction with no data access takes 5 cycles, a data read takes 7 and a store takes 6. No cycle carries more than one memory transfer.
- R2: The opcode values are: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 AND, 6 indexed load, 7 set index, 8 jump, 9 jump-if-zero, 0xA return-from-interrupt, 0xB enable interrupts. The operand is the word at the address held in the address field.
- R3: Add, subtract and AND combine the accumulator with the operand modulo 2^16, and load copies the operand. Each of these writes status bit 0 (zero flag) to 1 exactly when the new accumulator value is 0.
- R4: Store, the jumps, set index, enable interrupts and the undefined opcodes 0xC to 0xF leave the accumulator unchanged. The undefined opcodes do nothing.
- R5: Store writes the accumulator into the word at the address field.
- R6: Set index loads the index register from the operand. Indexed load reads the word at the address field plus the low 12 bits of the index register.
- R7: Jump replaces the already-incremented program counter with the address field. Jump-if-zero does the same only when the zero flag is 1; otherwise execution continues in sequence.
- R8: Every cycle `irq` is sampled into a pending latch, so a one-cycle pulse is enough. The request is accepted only at the end of an instruction and only while status bit 1 (interrupt enable) is 1. While interrupts are disabled the request stays pending and has no effect.
- R9: Accepting an interrupt writes three words, one per cycle: the program counter (the address of the next instruction) to 0xFF0, the accumulator to 0xFF1 and the status word to 0xFF2. It then sets the program counter to 0x010 and clears the interrupt enable bit.
- R10: Return-from-interrupt reads 0xFF0, 0xFF1 and 0xFF2 one per cycle into the program counter, accumulator and status word, and sets interrupt enable.
- R11: Halt sets `halted`. After that the program counter and the other registers stay frozen and `irq` has no effect until reset.
- R12: While `rst` is high or `halted` is 1, the host port owns the memory. `host_we` writes `host_wdata` at `host_addr` on the clock edge, and `host_rdata` shows the word at `host_addr` one cycle later. Reset does not clear the memory.
- R13: Reset sets the program counter, accumulator, index register and status word to 0, sets `halted` to 0 and clears any pending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Interrupt request |
| host_we | input | 1 | Host memory write strobe |
| host_addr | input | 12 | Host memory word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, one cycle after the address |
| halted | output | 1 | Core has executed a halt |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |
| ix | output | 16 | Index register |
| sr | output | 16 | Status word (bit 0 zero, bit 1 interrupt enable) |

## Verification
The hardest case to reach from the ports is a request that arrives while interrupts are disabled and is accepted only after a later instruction enables them. To reach it, the bench pulses `irq` for a single cycle during a load, at a cycle number computed from the documented per-instruction cycle counts. An enable instruction then follows. The save-area contents, the side effect left by the service routine and the registers restored after the return are read back at the end. Two companion runs cover the other cases: a request accepted at the end of a load, and a request that is never accepted because interrupts stay disabled.

// File: rtl/accum_pkg.sv
package accum_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OPC_W-1:0] OP_AND   = 4'h5;
  localparam logic [OPC_W-1:0] OP_LOADX = 4'h6;
  localparam logic [OPC_W-1:0] OP_SETX  = 4'h7;
  localparam logic [OPC_W-1:0] OP_JUMP  = 4'h8;
  localparam logic [OPC_W-1:0] OP_JZERO = 4'h9;
  localparam logic [OPC_W-1:0] OP_RETI  = 4'hA;
  localparam logic [OPC_W-1:0] OP_INTEN = 4'hB;

  localparam int SR_Z  = 0;
  localparam int SR_IE = 1;

  typedef enum logic [1:0] {
    ALU_PASS,
    ALU_ADD,
    ALU_SUB,
    ALU_AND
  } alu_op_e;

  typedef enum logic [4:0] {
    ST_FADDR,
    ST_FREAD,
    ST_FLATCH,
    ST_DECODE,
    ST_OPREAD,
    ST_EXEC,
    ST_OPWRITE,
    ST_CHECK,
    ST_SAVE0,
    ST_SAVE1,
    ST_SAVE2,
    ST_REST0,
    ST_REST1,
    ST_REST2,
    ST_REST3,
    ST_HALT
  } cyc_state_e;

endpackage

// File: rtl/accum_alu.sv
module accum_alu
  import accum_pkg::*;
#(
  parameter int DW = 16
)(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y,
  output logic          zero
);

  always_comb begin
    unique case (op)
      ALU_PASS: y = b;
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      default:  y = b;
    endcase
    zero = (y == '0);
  end

endmodule

// File: rtl/accum_mem.sv
module accum_mem #(
  parameter int DW = 16,
  parameter int AW = 12
)(
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  // Single port, registered read: rdata acts as the memory data register.
  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
    if (re) rdata <= store_q[addr];
  end

endmodule

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter int ISR_VEC = 16
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          irq,
  input  logic [DW-1:0] mdr,
  input  logic [DW-1:0] alu_y,
  input  logic          alu_zero,
  output alu_op_e       alu_op,
  output logic          mem_we,
  output logic          mem_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output cyc_state_e    state,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] mar,
  output logic [DW-1:0] cir,
  output logic [DW-1:0] acc,
  output logic [DW-1:0] ix,
  output logic [DW-1:0] sr,
  output logic          pend
);

  localparam logic [AW-1:0] SAVE_BASE = AW'((1 << AW) - 16);
  localparam logic [AW-1:0] VEC       = AW'(ISR_VEC);
  localparam logic [AW-1:0] ONE       = AW'(1);
  localparam logic [DW-1:0] IE_MASK   = DW'(1) << SR_IE;

  logic [OPC_W-1:0] opc;
  logic [AW-1:0]    field;
  logic             take;

  assign opc   = cir[DW-1 -: OPC_W];
  assign field = cir[AW-1:0];
  assign take  = (state == ST_CHECK) && sr[SR_IE] && pend;

  // ALU function picked from the opcode; its result lands only in ST_EXEC.
  always_comb begin
    unique case (opc)
      OP_ADD:  alu_op = ALU_ADD;
      OP_SUB:  alu_op = ALU_SUB;
      OP_AND:  alu_op = ALU_AND;
      default: alu_op = ALU_PASS;
    endcase
  end

  // Every memory access goes through MAR.
  assign mem_addr = mar;
  assign mem_re   = (state == ST_FREAD) || (state == ST_OPREAD) ||
                    (state == ST_REST0) || (state == ST_REST1) ||
                    (state == ST_REST2);
  assign mem_we   = (state == ST_OPWRITE) || (state == ST_SAVE0) ||
                    (state == ST_SAVE1)   || (state == ST_SAVE2);

  always_comb begin
    unique case (state)
      ST_SAVE0: mem_wdata = DW'(pc);
      ST_SAVE2: mem_wdata = sr;
      default:  mem_wdata = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FADDR;
      pc    <= '0;
      mar   <= '0;
      cir   <= '0;
      acc   <= '0;
      ix    <= '0;
      sr    <= '0;
      pend  <= 1'b0;
    end else begin
      if (state != ST_HALT) pend <= irq | (pend & ~take);
      unique case (state)
        ST_FADDR: begin
          mar   <= pc;
          state <= ST_FREAD;
        end
        ST_FREAD: begin
          pc    <= pc + ONE;
          state <= ST_FLATCH;
        end
        ST_FLATCH: begin
          cir   <= mdr;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          unique case (opc)
            OP_HALT: state <= ST_HALT;
            OP_LOAD, OP_ADD, OP_SUB, OP_AND, OP_SETX: begin
              mar   <= field;
              state <= ST_OPREAD;
            end
            OP_LOADX: begin
              mar   <= field + ix[AW-1:0];
              state <= ST_OPREAD;
            end
            OP_STORE: begin
              mar   <= field;
              state <= ST_OPWRITE;
            end
            OP_JUMP: begin
              pc    <= field;
              state <= ST_CHECK;
            end
            OP_JZERO: begin
              if (sr[SR_Z]) pc <= field;
              state <= ST_CHECK;
            end
            OP_RETI: begin
              mar   <= SAVE_BASE;
              state <= ST_REST0;
            end
            OP_INTEN: begin
              sr[SR_IE] <= 1'b1;
              state     <= ST_CHECK;
            end
            default: state <= ST_CHECK;
          endcase
        end
        ST_OPREAD: state <= ST_EXEC;
        ST_EXEC: begin
          if (opc == OP_SETX) begin
            ix <= mdr;
          end else begin
            acc      <= alu_y;
            sr[SR_Z] <= alu_zero;
          end
          state <= ST_CHECK;
        end
        ST_OPWRITE: state <= ST_CHECK;
        ST_CHECK: begin
          if (take) begin
            mar   <= SAVE_BASE;
            state <= ST_SAVE0;
          end else begin
            state <= ST_FADDR;
          end
        end
        ST_SAVE0: begin
          mar   <= mar + ONE;
          state <= ST_SAVE1;
        end
        ST_SAVE1: begin
          mar   <= mar + ONE;
          state <= ST_SAVE2;
        end
        ST_SAVE2: begin
          pc        <= VEC;
          sr[SR_IE] <= 1'b0;
          state     <= ST_FADDR;
        end
        ST_REST0: begin
          mar   <= mar + ONE;
          state <= ST_REST1;
        end
        ST_REST1: begin
          pc    <= mdr[AW-1:0];
          mar   <= mar + ONE;
          state <= ST_REST2;
        end
        ST_REST2: begin
          acc   <= mdr;
          state <= ST_REST3;
        end
        ST_REST3: begin
          sr    <= mdr | IE_MASK;
          state <= ST_CHECK;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_HALT;
      endcase
    end
  end

endmodule

// File: rtl/accum_core.sv
module accum_core
  import accum_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int ISR_VEC = 16
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      irq,
  input  logic                      host_we,
  input  logic [WORD_W-OPC_W-1:0]   host_addr,
  input  logic [WORD_W-1:0]         host_wdata,
  output logic [WORD_W-1:0]         host_rdata,
  output logic                      halted,
  output logic [WORD_W-OPC_W-1:0]   pc,
  output logic [WORD_W-1:0]         acc,
  output logic [WORD_W-1:0]         ix,
  output logic [WORD_W-1:0]         sr
);

  localparam int ADDR_W = WORD_W - OPC_W;

  alu_op_e             alu_op;
  logic [WORD_W-1:0]   alu_y;
  logic                alu_zero;
  logic [WORD_W-1:0]   mdr;
  logic                core_we;
  logic                core_re;
  logic [ADDR_W-1:0]   core_addr;
  logic [WORD_W-1:0]   core_wdata;
  cyc_state_e          core_state;
  logic [ADDR_W-1:0]   core_mar;
  logic [WORD_W-1:0]   core_cir;
  logic                core_pend;
  logic                host_sel;
  logic                m_we;
  logic                m_re;
  logic [ADDR_W-1:0]   m_addr;
  logic [WORD_W-1:0]   m_wdata;

  accum_ctrl #(.DW(WORD_W), .AW(ADDR_W), .ISR_VEC(ISR_VEC)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .irq      (irq),
    .mdr      (mdr),
    .alu_y    (alu_y),
    .alu_zero (alu_zero),
    .alu_op   (alu_op),
    .mem_we   (core_we),
    .mem_re   (core_re),
    .mem_addr (core_addr),
    .mem_wdata(core_wdata),
    .state    (core_state),
    .pc       (pc),
    .mar      (core_mar),
    .cir      (core_cir),
    .acc      (acc),
    .ix       (ix),
    .sr       (sr),
    .pend     (core_pend)
  );

  accum_alu #(.DW(WORD_W)) u_alu (
    .op  (alu_op),
    .a   (acc),
    .b   (mdr),
    .y   (alu_y),
    .zero(alu_zero)
  );

  assign halted   = (core_state == ST_HALT);
  assign host_sel = rst | halted;
  assign m_we     = host_sel ? host_we    : core_we;
  assign m_re     = host_sel ? 1'b1       : core_re;
  assign m_addr   = host_sel ? host_addr  : core_addr;
  assign m_wdata  = host_sel ? host_wdata : core_wdata;

  accum_mem #(.DW(WORD_W), .AW(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (m_we),
    .re   (m_re),
    .addr (m_addr),
    .wdata(m_wdata),
    .rdata(mdr)
  );

  assign host_rdata = mdr;

endmodule

// File: rtl/accum_core_chk.sv
module accum_core_chk
  import accum_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 12,
  parameter int ISR_VEC = 16
)(
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input cyc_state_e    st,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] mar,
  input logic [DW-1:0] cir,
  input logic [DW-1:0] mdr,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] sr,
  input logic          pend,
  input logic          core_we,
  input logic          core_re,
  input logic          halted
);

  localparam logic [AW-1:0] VEC = AW'(ISR_VEC);

  logic [OPC_W-1:0] opc;
  assign opc = cir[DW-1 -: OPC_W];

  a_r1_mar_from_pc: assert property (@(posedge clk) disable iff (rst)
    st == ST_FADDR |=> mar == $past(pc));

  a_r1_pc_steps: assert property (@(posedge clk) disable iff (rst)
    st == ST_FREAD |=> pc == AW'($past(pc) + AW'(1)));

  a_r1_cir_from_mdr: assert property (@(posedge clk) disable iff (rst)
    st == ST_FLATCH |=> cir == $past(mdr));

  a_r1_one_transfer: assert property (@(posedge clk) disable iff (rst)
    !(core_we && core_re));

  a_r3_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (st == ST_EXEC && opc != OP_SETX) |=> sr[SR_Z] == (acc == '0));

  a_r4_acc_hold: assert property (@(posedge clk) disable iff (rst)
    !(st == ST_EXEC || st == ST_REST2) |=> $stable(acc));

  a_r8_pend_latch: assert property (@(posedge clk) disable iff (rst)
    (irq && !halted) |=> pend);

  a_r8_take: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && sr[SR_IE] && pend) |=> st == ST_SAVE0);

  a_r8_masked: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CHECK && !sr[SR_IE]) |=> st == ST_FADDR);

  a_r9_vector: assert property (@(posedge clk) disable iff (rst)
    st == ST_SAVE2 |=> (pc == VEC && !sr[SR_IE]));

  a_r10_reenable: assert property (@(posedge clk) disable iff (rst)
    st == ST_REST3 |=> sr[SR_IE]);

  a_r11_halt_sticky: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc) && $stable(acc)));

endmodule

bind accum_core accum_core_chk #(.DW(WORD_W), .AW(ADDR_W), .ISR_VEC(ISR_VEC)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .irq    (irq),
  .st     (core_state),
  .pc     (pc),
  .mar    (core_mar),
  .cir    (core_cir),
  .mdr    (mdr),
  .acc    (acc),
  .sr     (sr),
  .pend   (core_pend),
  .core_we(core_we),
  .core_re(core_re),
  .halted (halted)
);

// File: tb/accum_core_test.sv
module accum_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        irq = 1'b0;
  logic        host_we = 1'b0;
  logic [11:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  wire  [15:0] host_rdata;
  wire         halted;
  wire  [11:0] pc;
  wire  [15:0] acc;
  wire  [15:0] ix;
  wire  [15:0] sr;

  always #5 clk = ~clk;

  accum_core uut (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .host_we   (host_we),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .halted    (halted),
    .pc        (pc),
    .acc       (acc),
    .ix        (ix),
    .sr        (sr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // {opcode, first operand, second operand, expected accumulator}
  localparam logic [63:0] TV [0:7] = '{
    64'h0003_1234_0101_1335,
    64'h0003_FFFF_0001_0000,
    64'h0004_0003_0005_FFFE,
    64'h0004_0042_0042_0000,
    64'h0005_F0F0_0FF0_00F0,
    64'h0005_AAAA_5555_0000,
    64'h0001_1111_8001_8001,
    64'h000C_7777_0000_7777
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic get(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(input int irq_at, output int cyc);
    @(negedge clk);
    rst = 1'b0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      irq = (cyc == irq_at);
    end
    irq = 1'b0;
  endtask

  task automatic load_isr();
    put(12'h010, 16'h1103);
    put(12'h011, 16'h2104);
    put(12'h012, 16'hA000);
    put(12'h103, 16'h0000);
    put(12'h104, 16'hFFFF);
    put(12'hFF0, 16'hDEAD);
    put(12'hFF1, 16'hDEAD);
    put(12'hFF2, 16'hDEAD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [15:0] rd;

    // R13: reset state before anything runs
    repeat (3) @(negedge clk);
    chk("R13 pc", pc, 0);
    chk("R13 acc", acc, 0);
    chk("R13 halted", halted, 0);

    // R1 R2 R3 R4: table of two-instruction programs
    for (int i = 0; i < 8; i++) begin
      logic [3:0]  op;
      logic [15:0] a, b, e;
      op = TV[i][51:48]; a = TV[i][47:32]; b = TV[i][31:16]; e = TV[i][15:0];
      hold_reset();
      put(12'h000, 16'h1100);
      put(12'h001, {op, 12'h101});
      put(12'h002, 16'h0000);
      put(12'h100, a);
      put(12'h101, b);
      run(-1, cyc);
      chk($sformatf("R3 R4 acc vec %0d", i), acc, e);
      chk($sformatf("R3 zero flag vec %0d", i), sr, (e == 16'h0) ? 1 : 0);
      chk($sformatf("R2 pc vec %0d", i), pc, 3);
      chk($sformatf("R1 cycles vec %0d", i), cyc, (op == 4'hC) ? 16 : 18);
    end

    // R13: reset clears registers that were left non-zero
    hold_reset();
    chk("R13 acc after reset", acc, 0);
    chk("R13 pc after reset", pc, 0);
    chk("R13 sr after reset", sr, 0);
    chk("R13 halted after reset", halted, 0);

    // R1 R11: halt at address 0, then stays frozen under irq
    put(12'h000, 16'h0000);
    run(-1, cyc);
    chk("R1 halt latency", cyc, 4);
    chk("R1 pc after one fetch", pc, 1);
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    repeat (6) @(negedge clk);
    chk("R11 halted sticky", halted, 1);
    chk("R11 pc frozen", pc, 1);

    // R7 R4: jumps
    hold_reset();
    put(12'h000, 16'h1105); put(12'h001, 16'h9004); put(12'h002, 16'h1106);
    put(12'h003, 16'h0000); put(12'h004, 16'h1106); put(12'h005, 16'h8008);
    put(12'h006, 16'h0000); put(12'h007, 16'h0000); put(12'h008, 16'h9003);
    put(12'h009, 16'h0000); put(12'h105, 16'h0000); put(12'h106, 16'h0007);
    run(-1, cyc);
    chk("R7 jump path pc", pc, 12'h00A);
    chk("R4 acc kept over jumps", acc, 7);

    // R6: index register and indexed load
    hold_reset();
    put(12'h000, 16'h7107); put(12'h001, 16'h6110); put(12'h002, 16'h0000);
    put(12'h107, 16'h0003); put(12'h110, 16'h5555); put(12'h113, 16'h1234);
    run(-1, cyc);
    chk("R6 ix loaded", ix, 3);
    chk("R6 indexed load", acc, 16'h1234);

    // R8 R9 R10 R5: request taken at end of a load
    hold_reset();
    put(12'h000, 16'hB000); put(12'h001, 16'h1100); put(12'h002, 16'h3101);
    put(12'h003, 16'h2102); put(12'h004, 16'h0000);
    put(12'h100, 16'h0005); put(12'h101, 16'h0003); put(12'h102, 16'h0000);
    load_isr();
    run(7, cyc);
    get(12'hFF0, rd); chk("R9 saved pc", rd, 2);
    get(12'hFF1, rd); chk("R9 saved acc", rd, 5);
    get(12'hFF2, rd); chk("R9 saved sr", rd, 2);
    get(12'h104, rd); chk("R9 service routine ran", rd, 0);
    get(12'h102, rd); chk("R5 R12 store result", rd, 8);
    chk("R10 acc after resume", acc, 8);
    chk("R10 sr after resume", sr, 2);
    chk("R10 pc at halt", pc, 5);

    // R8: request ignored while interrupts stay disabled
    hold_reset();
    put(12'h000, 16'h1100); put(12'h001, 16'h3101); put(12'h002, 16'h2102);
    put(12'h003, 16'h0000); put(12'h102, 16'h0000);
    load_isr();
    run(3, cyc);
    get(12'hFF0, rd); chk("R8 masked no save", rd, 16'hDEAD);
    get(12'h104, rd); chk("R8 masked no routine", rd, 16'hFFFF);
    chk("R8 masked pc", pc, 4);
    chk("R8 masked acc", acc, 8);

    // R8 R9 R10: pending request accepted after enabling
    hold_reset();
    put(12'h000, 16'h1100); put(12'h001, 16'hB000); put(12'h002, 16'h0000);
    put(12'h100, 16'h0005);
    load_isr();
    run(2, cyc);
    get(12'hFF0, rd); chk("R8 deferred saved pc", rd, 2);
    get(12'hFF1, rd); chk("R9 deferred saved acc", rd, 5);
    get(12'hFF2, rd); chk("R9 deferred saved sr", rd, 2);
    get(12'h104, rd); chk("R8 deferred routine ran", rd, 0);
    chk("R10 deferred acc restored", acc, 5);
    chk("R10 deferred sr restored", sr, 2);
    chk("R10 deferred pc", pc, 3);

    // R12: memory survives reset
    hold_reset();
    get(12'h113, rd); chk("R12 memory kept over reset", rd, 16'h1234);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule